// File: doc/BRIEF.md
# Write-Protect Unlock Sequence Detector

This block sits between a byte-write stream and a page buffer. Each write arrives as an address/data pair with a one-cycle valid strobe. Consecutive writes form a load. A load stays open while writes keep arriving within a fixed window of idle clock edges. The block looks for two command sequences at the start of each load. The three-byte sequence turns protection on and unlocks the current load. The six-byte sequence turns protection off.

For every byte, the block reports one of three outcomes. The byte is accepted as data, or it is consumed as a command byte, or it is suppressed. When a load closes, the block pulses a start request for the programming timer. It flags that request as empty when no byte of the load was stored. A protected write without the sequence therefore still runs a write period and stores nothing.

A decoded command does not change protection right away. The new state is held as pending and applies when the external timer reports the end of the write period. The protect flag is cleared only by the power-on reset input. The ordinary reset clears the load and sequence state but keeps the flag.

Top module: `wr_protect_seq`

## Requirements
- R1: After power-on reset, protect_on, byte_ok, byte_cmd, prog_start and prog_empty are all 0.
- R2: While unprotected, a write that is not part of a command sequence gives byte_ok=1 and byte_cmd=0 in the cycle after the clock edge that captures it.
- R3: The enable sequence is data 0xAA at address 0x1555, then 0x55 at 0x0AAA, then 0xA0 at 0x1555, given as the first bytes of a load. Each of these bytes gives byte_cmd=1 and byte_ok=0. protect_on becomes 1 on the edge where prog_done is seen after that load closes, even when no data byte follows.
- R4: While protected, a load without a leading command sequence has every byte give byte_ok=0 and byte_cmd=0. The load still ends with prog_start, with prog_empty=1.
- R5: While protected, data bytes that follow the enable sequence in the same load are accepted (byte_ok=1). The load ends with prog_empty=0, and protection stays on.
- R6: The disable sequence is 0xAA@0x1555, 0x55@0x0AAA, 0x80@0x1555, 0xAA@0x1555, 0x55@0x0AAA, 0x20@0x1555 at the start of a load. All six bytes give byte_cmd=1. Data that follows in the same load is accepted. protect_on becomes 0 at the next prog_done.
- R7: A byte that breaks a partly matched sequence is handled as data under the current protection state, and so is every later byte of that load. Bytes that matched before the break stay marked as command bytes.
- R8: A load closes after LOAD_WINDOW consecutive clock edges without a write. prog_start then pulses for one cycle, LOAD_WINDOW cycles after the last write was captured. A gap of LOAD_WINDOW-1 idle edges keeps the load, and any sequence in progress, open.
- R9: Command patterns count only at the start of a load. After a data byte, a byte of 0xAA at 0x1555 is ordinary data, so command addresses can receive user data.
- R10: Writes from prog_start until prog_done give byte_ok=0 and byte_cmd=0. A prog_done pulse outside that period has no effect.
- R11: rst_n does not change protect_on. Only por_n clears it.
- R12: protect_on changes only on a clock edge where prog_done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low; clears everything including the protect flag |
| rst_n | input | 1 | Asynchronous reset, active low; clears load and sequence state, keeps the protect flag |
| wr_valid | input | 1 | One-cycle strobe marking a byte write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| prog_done | input | 1 | End of the write period, from the programming timer |
| byte_ok | output | 1 | The byte captured on the previous edge may be stored |
| byte_cmd | output | 1 | The byte captured on the previous edge is a command byte, not data |
| prog_start | output | 1 | One-cycle pulse: the load has closed and the write timer should start |
| prog_empty | output | 1 | With prog_start: nothing from this load was accepted |
| protect_on | output | 1 | Current protection state |

## Verification
byte_ok and byte_cmd are due one cycle after the edge that captures the write. prog_start is due exactly LOAD_WINDOW cycles after the last captured write. protect_on changes on the edge that sees prog_done. The bench drives every input on a falling edge, so each byte result is read at the very next falling edge. It counts falling edges from the last write until prog_start and compares that count with LOAD_WINDOW. It also reads protect_on once before and once after the prog_done pulse, to confirm that nothing changes early.

// File: rtl/wr_protect_seq.sv
module wr_protect_seq #(
  parameter int ADDR_W      = 13,
  parameter int DATA_W      = 8,
  parameter int LOAD_WINDOW = 16,
  parameter logic [ADDR_W-1:0] KEY_ADDR_A = 'h1555,
  parameter logic [ADDR_W-1:0] KEY_ADDR_B = 'h0AAA
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              prog_done,
  output logic              byte_ok,
  output logic              byte_cmd,
  output logic              prog_start,
  output logic              prog_empty,
  output logic              protect_on
);
  localparam int CW = $clog2(LOAD_WINDOW + 1);
  localparam logic [DATA_W-1:0] K_LEAD = 'hAA;
  localparam logic [DATA_W-1:0] K_SECOND = 'h55;
  localparam logic [DATA_W-1:0] K_SET = 'hA0;
  localparam logic [DATA_W-1:0] K_CLR_PRE = 'h80;
  localparam logic [DATA_W-1:0] K_CLR = 'h20;
  localparam logic [CW-1:0] CNT_LAST = CW'(LOAD_WINDOW - 1);

  logic          busy, in_load, seq_live, unlock, any_acc, pend_v, pend_val;
  logic [2:0]    seq_pos;
  logic [CW-1:0] idle_cnt;
  logic          step_ok;

  wire ctl_rst_n = por_n & rst_n;
  wire take      = wr_valid && !busy;
  wire [2:0] pos = in_load ? seq_pos : 3'd0;
  wire live      = !in_load || seq_live;
  wire at_a      = (wr_addr == KEY_ADDR_A);
  wire at_b      = (wr_addr == KEY_ADDR_B);

  always_comb begin
    case (pos)
      3'd0:    step_ok = at_a && wr_data == K_LEAD;
      3'd1:    step_ok = at_b && wr_data == K_SECOND;
      3'd2:    step_ok = at_a && (wr_data == K_SET || wr_data == K_CLR_PRE);
      3'd3:    step_ok = at_a && wr_data == K_LEAD;
      3'd4:    step_ok = at_b && wr_data == K_SECOND;
      3'd5:    step_ok = at_a && wr_data == K_CLR;
      default: step_ok = 1'b0;
    endcase
  end

  wire is_cmd   = take && live && step_ok;
  wire fin_on   = is_cmd && pos == 3'd2 && wr_data == K_SET;
  wire fin_off  = is_cmd && pos == 3'd5;
  wire data_ok  = take && !is_cmd && (!protect_on || unlock);
  wire idle_edg = in_load && !busy && !wr_valid;
  wire close    = idle_edg && idle_cnt == CNT_LAST;

  always_ff @(posedge clk or negedge ctl_rst_n) begin
    if (!ctl_rst_n) begin
      byte_ok <= 1'b0; byte_cmd <= 1'b0; prog_start <= 1'b0; prog_empty <= 1'b0;
      busy <= 1'b0; in_load <= 1'b0; seq_live <= 1'b0; seq_pos <= 3'd0;
      unlock <= 1'b0; any_acc <= 1'b0; pend_v <= 1'b0; pend_val <= 1'b0;
      idle_cnt <= '0;
    end else begin
      byte_ok    <= data_ok;
      byte_cmd   <= is_cmd;
      prog_start <= close;
      prog_empty <= close && !any_acc;
      if (take) begin
        in_load  <= 1'b1;
        idle_cnt <= '0;
        if (data_ok) any_acc <= 1'b1;
        if (is_cmd) begin
          if (fin_on || fin_off) begin
            seq_live <= 1'b0;
            unlock   <= 1'b1;
            pend_v   <= 1'b1;
            pend_val <= fin_on;
          end else begin
            seq_pos  <= pos + 3'd1;
            seq_live <= 1'b1;
          end
        end else begin
          seq_live <= 1'b0;
        end
      end else if (close) begin
        in_load  <= 1'b0;
        busy     <= 1'b1;
        seq_live <= 1'b0;
        seq_pos  <= 3'd0;
        unlock   <= 1'b0;
        any_acc  <= 1'b0;
        idle_cnt <= '0;
      end else if (idle_edg) begin
        idle_cnt <= idle_cnt + 1'b1;
      end
      if (busy && prog_done) begin
        busy   <= 1'b0;
        pend_v <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                         protect_on <= 1'b0;
    else if (busy && prog_done && pend_v) protect_on <= pend_val;
  end

  // R3
  cmd_excl_chk: assert property (@(posedge clk) disable iff (!ctl_rst_n)
    !(byte_ok && byte_cmd));

  // R2
  byte_src_chk: assert property (@(posedge clk) disable iff (!ctl_rst_n)
    (byte_ok || byte_cmd) |-> $past(wr_valid));

  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!ctl_rst_n)
    $past(busy && wr_valid) |-> !(byte_ok || byte_cmd));

  // R12
  prot_change_chk: assert property (@(posedge clk) disable iff (!ctl_rst_n)
    !$stable(protect_on) |-> $past(prog_done));

  // R4
  empty_with_start_chk: assert property (@(posedge clk) disable iff (!ctl_rst_n)
    prog_empty |-> prog_start);

  // R8
  start_after_idle_chk: assert property (@(posedge clk) disable iff (!ctl_rst_n)
    prog_start |-> !$past(wr_valid));

  // R8
  start_pulse_chk: assert property (@(posedge clk) disable iff (!ctl_rst_n)
    prog_start |=> !prog_start);
endmodule

// File: tb/wr_protect_seq_test.sv
module wr_protect_seq_test;
  localparam int WIN = 8;

  logic        clk = 1'b0;
  logic        por_n = 1'b0, rst_n = 1'b0;
  logic        wr_valid = 1'b0, prog_done = 1'b0;
  logic [12:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        byte_ok, byte_cmd, prog_start, prog_empty, protect_on;

  int checks = 0, fails = 0;
  bit ended = 1'b0;
  logic got_ok, got_cmd, got_empty;
  int   got_cnt;

  always #2 clk = ~clk;

  wr_protect_seq #(.LOAD_WINDOW(WIN)) uut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .prog_done(prog_done),
    .byte_ok(byte_ok), .byte_cmd(byte_cmd), .prog_start(prog_start),
    .prog_empty(prog_empty), .protect_on(protect_on));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic put(logic [12:0] a, logic [7:0] d);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    got_ok = byte_ok; got_cmd = byte_cmd;
    wr_valid = 1'b0;
  endtask

  task automatic put_chk(string req, logic [12:0] a, logic [7:0] d, int ok, int cmd);
    put(a, d);
    check({req, " ok"}, got_ok, ok);
    check({req, " cmd"}, got_cmd, cmd);
  endtask

  task automatic wait_close();
    got_cnt = 0;
    for (int i = 0; i < 4 * WIN; i++) begin
      @(negedge clk);
      got_cnt++;
      if (prog_start) break;
    end
    got_empty = prog_empty;
  endtask

  task automatic finish_period();
    prog_done = 1'b1;
    @(negedge clk);
    prog_done = 1'b0;
  endtask

  task automatic enable_seq(string req);
    put_chk(req, 13'h1555, 8'hAA, 0, 1);
    put_chk(req, 13'h0AAA, 8'h55, 0, 1);
    put_chk(req, 13'h1555, 8'hA0, 0, 1);
  endtask

  task automatic t_reset();
    por_n = 1'b0; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
    check("R1 protect", protect_on, 0);
    check("R1 byte_ok", byte_ok, 0);
    check("R1 byte_cmd", byte_cmd, 0);
    check("R1 prog_start", prog_start, 0);
    check("R1 prog_empty", prog_empty, 0);
  endtask

  task automatic t_plain();
    put_chk("R2", 13'h0040, 8'h11, 1, 0);
    put_chk("R2", 13'h0041, 8'h22, 1, 0);
    wait_close();
    check("R8 close count", got_cnt, WIN);
    check("R8 empty", got_empty, 0);
    finish_period();
    check("R2 protect", protect_on, 0);
  endtask

  task automatic t_late_cmd();
    put_chk("R9 data", 13'h0100, 8'h12, 1, 0);
    put_chk("R9 key-like", 13'h1555, 8'hAA, 1, 0);
    wait_close();
    finish_period();
    check("R9 protect", protect_on, 0);
  endtask

  task automatic t_enable_gap();
    put_chk("R3", 13'h1555, 8'hAA, 0, 1);
    repeat (WIN - 1) @(negedge clk);
    put_chk("R8 gap", 13'h0AAA, 8'h55, 0, 1);
    repeat (WIN - 1) @(negedge clk);
    put_chk("R8 gap", 13'h1555, 8'hA0, 0, 1);
    wait_close();
    check("R8 close count", got_cnt, WIN);
    check("R3 empty", got_empty, 1);
    repeat (3) @(negedge clk);
    check("R12 early", protect_on, 0);
    finish_period();
    check("R3 protect", protect_on, 1);
  endtask

  task automatic t_blocked();
    put_chk("R4", 13'h0200, 8'h5A, 0, 0);
    put_chk("R4", 13'h0201, 8'hA5, 0, 0);
    wait_close();
    check("R4 start", got_cnt, WIN);
    check("R4 empty", got_empty, 1);
    finish_period();
    check("R4 protect", protect_on, 1);
  endtask

  task automatic t_unlocked();
    enable_seq("R5");
    put_chk("R5", 13'h0300, 8'h01, 1, 0);
    put_chk("R5", 13'h0301, 8'h02, 1, 0);
    put_chk("R5", 13'h0302, 8'h03, 1, 0);
    wait_close();
    check("R5 empty", got_empty, 0);
    put_chk("R10 busy", 13'h1555, 8'hAA, 0, 0);
    put_chk("R10 busy", 13'h0004, 8'h44, 0, 0);
    finish_period();
    check("R5 protect", protect_on, 1);
    finish_period();
    check("R10 stray done", protect_on, 1);
    put_chk("R10 after stray", 13'h0005, 8'h55, 0, 0);
    wait_close();
    check("R10 empty", got_empty, 1);
    finish_period();
  endtask

  task automatic t_mismatch();
    put_chk("R7", 13'h1555, 8'hAA, 0, 1);
    put_chk("R7", 13'h0AAA, 8'h55, 0, 1);
    put_chk("R7 break", 13'h1555, 8'h33, 0, 0);
    put_chk("R7 rest", 13'h1555, 8'hA0, 0, 0);
    wait_close();
    check("R7 empty", got_empty, 1);
    finish_period();
    check("R7 protect", protect_on, 1);
  endtask

  task automatic t_rst();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 rst keeps", protect_on, 1);
  endtask

  task automatic t_disable();
    put_chk("R6", 13'h1555, 8'hAA, 0, 1);
    put_chk("R6", 13'h0AAA, 8'h55, 0, 1);
    put_chk("R6", 13'h1555, 8'h80, 0, 1);
    put_chk("R6", 13'h1555, 8'hAA, 0, 1);
    put_chk("R6", 13'h0AAA, 8'h55, 0, 1);
    put_chk("R6", 13'h1555, 8'h20, 0, 1);
    put_chk("R6 data", 13'h0400, 8'h77, 1, 0);
    wait_close();
    check("R6 empty", got_empty, 0);
    check("R12 before done", protect_on, 1);
    finish_period();
    check("R6 protect", protect_on, 0);
  endtask

  task automatic t_por();
    enable_seq("R11");
    wait_close();
    finish_period();
    check("R11 set", protect_on, 1);
    por_n = 1'b0;
    @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    check("R11 por clears", protect_on, 0);
    check("R1 after por", byte_ok, 0);
  endtask

  initial begin
    t_reset();
    t_plain();
    t_late_cmd();
    t_enable_gap();
    t_blocked();
    t_unlocked();
    t_mismatch();
    t_rst();
    t_disable();
    t_por();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule